// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block turns a 64-bit virtual address into a 40-bit physical address. It holds a small fully associative set of page translations. Pages are 4096 bytes, so the low 12 address bits are the page offset and pass through unchanged. The upper 52 bits are the virtual page number, and every slot compares it against its stored tag in parallel. On a hit the translation returns in the same cycle as the request. Each request is tagged as an instruction fetch, a data read or a data write.

On a miss the block captures the request and sends the page number to an external page-table port. It then waits for that port to answer. A resident answer installs the translation in a free slot, or else in the least recently used slot, and completes the waiting access. A non-resident answer completes the access as a page fault and installs nothing. Each slot keeps a dirty flag and a read-only flag. A write to a read-only page completes with a protection fault and leaves the page clean. A flush input discards every translation.

The controller has three states:
- IDLE: lookups are served.
- ISSUE: the page-table request pulses for one cycle.
- WAIT: the block waits for the page-table answer.

The transitions are:
- Miss: IDLE to ISSUE, on an accepted request that does not match any slot.
- Sent: ISSUE to WAIT, unconditionally.
- Answered: WAIT to IDLE, when a page-table response arrives.

Top module: `xlate_cache`

## Requirements
- R1: A request accepted in IDLE that matches a valid slot asserts `done` in the same cycle. `done_paddr` equals {stored frame number, `req_vaddr[11:0]`}, and no page-table request is made.
- R2: A request in IDLE that matches no slot gives no `done` in that cycle. In the next cycle `pt_req` is high for exactly one cycle, with `pt_req_vpn` = `req_vaddr[63:12]`. In the cycle a response arrives, `done` rises. For a resident response, `done_paddr` = {`pt_rsp_ppn`, saved offset}.
- R3: A response with `pt_rsp_resident` = 0 completes the access with `done_pfault` = 1, `done_prot` = 0 and `done_dirty` = 0. It installs nothing, so the same page misses again on its next access.
- R4: A page installed by a resident response hits on its next access.
- R5: When all slots are valid, a miss replaces the slot whose last hit or install is oldest. Both hits and installs count as use.
- R6: Empty slots are filled before any valid slot is replaced, so four distinct pages installed after a flush or reset all hit afterwards.
- R7: A write (`req_kind` = 2) to a page whose response carried `pt_rsp_ro` = 1 completes with `done_prot` = 1 and `done_dirty` = 0, on a hit or on an install. The page's dirty flag stays clear.
- R8: A write to a writable page sets that page's dirty flag. `done_dirty` shows the flag after the access. A read (`req_kind` = 1) or fetch (`req_kind` = 0) reports the flag unchanged, and an install by a read or fetch leaves it clear.
- R9: While `flush` is high, a request is ignored, with no `done` and no page-table request. After a flush, every page misses.
- R10: `busy` is high from the cycle after a miss until the cycle after the response. Requests presented while busy are ignored and do not change the translation that completes.
- R11: Fetches and reads of read-only pages, and a `req_kind` of 3 (treated as a read), never raise `done_prot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translations |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_vaddr | input | 64 | Virtual address |
| done | output | 1 | Access completes this cycle |
| done_paddr | output | 40 | Physical address |
| done_pfault | output | 1 | Page not resident |
| done_prot | output | 1 | Write to read-only page |
| done_dirty | output | 1 | Page dirty flag after the access |
| busy | output | 1 | Miss outstanding; requests ignored |
| pt_req | output | 1 | Page-table lookup request pulse |
| pt_req_vpn | output | 52 | Page number to look up |
| pt_rsp_valid | input | 1 | Page-table answer strobe |
| pt_rsp_resident | input | 1 | Page is resident |
| pt_rsp_ro | input | 1 | Page is read-only (instruction page) |
| pt_rsp_ppn | input | 28 | Frame number |

## Verification
Replacement order is the main target. The bench tracks use stamps per slot and exercises evictions after hits have reshuffled the order. A design that aged only on installs, or that chose a fixed slot, would then evict a recently hit page, and a following access would miss where a hit is expected. Write protection is checked on both the hit path and the install path: a design that marked read-only pages dirty would report `done_dirty` on a later read. Stray requests are driven during a miss, so a design that latched them would put a wrong page number on the port or return a wrong address. Non-resident answers must not install a page, and a flush must discard every page, including pages touched just before it.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int N     = 4,
    parameter int VPN_W = 52,
    parameter int PPN_W = 28
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [VPN_W-1:0]          lk_vpn,
    output logic                      lk_hit,
    output logic [$clog2(N)-1:0]      lk_idx,
    output logic [PPN_W-1:0]          lk_ppn,
    output logic                      lk_dirty,
    output logic                      lk_ro,
    output logic [N-1:0]              valid_vec,
    input  logic                      wr_en,
    input  logic [$clog2(N)-1:0]      wr_idx,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [PPN_W-1:0]          wr_ppn,
    input  logic                      wr_ro,
    input  logic                      wr_dirty,
    input  logic                      dset_en,
    input  logic [$clog2(N)-1:0]      dset_idx
);
    localparam int IDX_W = $clog2(N);

    logic [VPN_W-1:0] tag_q   [N];
    logic [PPN_W-1:0] ppn_q   [N];
    logic [N-1:0]     valid_q;
    logic [N-1:0]     dirty_q;
    logic [N-1:0]     ro_q;
    logic [N-1:0]     match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_idx = IDX_W'(i);
        end
        lk_hit   = |match;
        lk_ppn   = ppn_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
        lk_ro    = ro_q[lk_idx];
    end

    assign valid_vec = valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ro_q    <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= wr_vpn;
                    ppn_q[i]   <= wr_ppn;
                    ro_q[i]    <= wr_ro;
                    dirty_q[i] <= wr_dirty;
                end else if (dset_en && dset_idx == IDX_W'(i)) begin
                    dirty_q[i] <= 1'b1;
                end
            end
            if (flush) valid_q <= '0;
        end
    end

    // R4: a page lives in at most one slot
    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7: a read-only slot never becomes dirty
    assert_ro_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dset_en && ro_q[dset_idx]) |-> 1'b0);
endmodule

// File: rtl/xlate_lru.sv
module xlate_lru #(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  touch_en,
    input  logic [$clog2(N)-1:0]  touch_idx,
    input  logic [N-1:0]          valid_vec,
    output logic [$clog2(N)-1:0]  victim_idx
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    logic [IDX_W-1:0] age_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_rank
        logic [N-1:0] at_rank;
        for (genvar k = 0; k < N; k++) begin : g_cell
            assign at_rank[k] = (age_q[k] == IDX_W'(r));
        end
        // R5: ranks always form a permutation
        assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(at_rank) == 1);
    end

    // R5: a touched slot becomes most recently used
    assert_mru_after_touch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xlate_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 40,
    parameter int OFS_W   = 12,
    parameter int ENTRIES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    req_valid,
    input  logic [1:0]              req_kind,
    input  logic [VA_W-1:0]         req_vaddr,
    output logic                    done,
    output logic [PA_W-1:0]         done_paddr,
    output logic                    done_pfault,
    output logic                    done_prot,
    output logic                    done_dirty,
    output logic                    busy,
    output logic                    pt_req,
    output logic [VA_W-OFS_W-1:0]   pt_req_vpn,
    input  logic                    pt_rsp_valid,
    input  logic                    pt_rsp_resident,
    input  logic                    pt_rsp_ro,
    input  logic [PA_W-OFS_W-1:0]   pt_rsp_ppn
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    xl_state_e         state_q, state_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              wr_q;

    logic [VPN_W-1:0]  req_vpn;
    logic              req_wr;
    logic              accept, hit_go, miss_go, fill_go, fill_ok;
    logic              lk_hit, lk_dirty, lk_ro;
    logic [IDX_W-1:0]  lk_idx, victim_idx, touch_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [ENTRIES-1:0] valid_vec;

    assign req_vpn = req_vaddr[VA_W-1:OFS_W];
    assign req_wr  = (acc_kind_e'(req_kind) == ACC_WRITE);
    assign accept  = (state_q == ST_IDLE) && req_valid && !flush;
    assign hit_go  = accept && lk_hit;
    assign miss_go = accept && !lk_hit;
    assign fill_go = (state_q == ST_WAIT) && pt_rsp_valid;
    assign fill_ok = fill_go && pt_rsp_resident;
    assign touch_idx = hit_go ? lk_idx : victim_idx;

    xlate_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (req_vpn),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .lk_ppn    (lk_ppn),
        .lk_dirty  (lk_dirty),
        .lk_ro     (lk_ro),
        .valid_vec (valid_vec),
        .wr_en     (fill_ok),
        .wr_idx    (victim_idx),
        .wr_vpn    (vpn_q),
        .wr_ppn    (pt_rsp_ppn),
        .wr_ro     (pt_rsp_ro),
        .wr_dirty  (wr_q && !pt_rsp_ro),
        .dset_en   (hit_go && req_wr && !lk_ro),
        .dset_idx  (lk_idx)
    );

    xlate_lru #(.N(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (hit_go || fill_ok),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            ofs_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (miss_go) begin
                vpn_q <= req_vpn;
                ofs_q <= req_vaddr[OFS_W-1:0];
                wr_q  <= req_wr;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_go) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (pt_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        done        = 1'b0;
        done_paddr  = '0;
        done_pfault = 1'b0;
        done_prot   = 1'b0;
        done_dirty  = 1'b0;
        pt_req      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                done       = hit_go;
                done_paddr = {lk_ppn, req_vaddr[OFS_W-1:0]};
                done_prot  = hit_go && req_wr && lk_ro;
                done_dirty = hit_go && (lk_dirty || (req_wr && !lk_ro));
            end
            ST_ISSUE: pt_req = 1'b1;
            ST_WAIT: begin
                done        = fill_go;
                done_paddr  = {pt_rsp_ppn, ofs_q};
                done_pfault = fill_go && !pt_rsp_resident;
                done_prot   = fill_ok && wr_q && pt_rsp_ro;
                done_dirty  = fill_ok && wr_q && !pt_rsp_ro;
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign pt_req_vpn = vpn_q;

    // R2: the page-table request is a one-cycle pulse
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |=> !pt_req);

    // R2: a miss raises busy and the page-table request next cycle
    assert_miss_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !flush && !done) |=> (busy && pt_req));

    // R10: busy drops right after the answer
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pt_req && pt_rsp_valid) |=> !busy);

    // R3: a page fault carries no protection or dirty report
    assert_fault_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_pfault) |-> (!done_prot && !done_dirty));

    // R7: a protection fault never reports dirty
    assert_prot_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_prot) |-> !done_dirty);

    // R9: nothing completes in a flush cycle unless a miss is being answered
    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !busy) |-> !done);
endmodule

// File: tb/sim_xlate_cache.sv
module sim_xlate_cache;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [63:0] req_vaddr = '0;
    logic        done, done_pfault, done_prot, done_dirty, busy, pt_req;
    logic [39:0] done_paddr;
    logic [51:0] pt_req_vpn;
    logic        pt_rsp_valid = 1'b0, pt_rsp_resident = 1'b0, pt_rsp_ro = 1'b0;
    logic [27:0] pt_rsp_ppn = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    xlate_cache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_kind(req_kind), .req_vaddr(req_vaddr), .done(done),
        .done_paddr(done_paddr), .done_pfault(done_pfault), .done_prot(done_prot),
        .done_dirty(done_dirty), .busy(busy), .pt_req(pt_req), .pt_req_vpn(pt_req_vpn),
        .pt_rsp_valid(pt_rsp_valid), .pt_rsp_resident(pt_rsp_resident),
        .pt_rsp_ro(pt_rsp_ro), .pt_rsp_ppn(pt_rsp_ppn)
    );

    // page-table model
    function automatic bit pt_res(input logic [51:0] v);
        return (v % 7) != 3;
    endfunction
    function automatic logic [27:0] pt_ppn(input logic [51:0] v);
        return 28'(v * 13 + 5);
    endfunction
    function automatic bit pt_rdonly(input logic [51:0] v);
        return v[1];
    endfunction

    // reference translation cache: true LRU by use stamps
    bit          m_valid [4];
    logic [51:0] m_vpn   [4];
    bit          m_dirty [4];
    bit          m_ro    [4];
    int          m_stamp [4];
    int          now_stamp = 0;

    function automatic int m_find(input logic [51:0] v);
        for (int i = 0; i < 4; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction
    function automatic int m_victim();
        int best = 0;
        for (int i = 0; i < 4; i++) if (!m_valid[i]) return i;
        for (int i = 1; i < 4; i++) if (m_stamp[i] < m_stamp[best]) best = i;
        return best;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] kind, input logic [63:0] va,
                          input bit stray, input int delay, output bit was_hit);
        logic [51:0] vpn = va[63:12];
        bit wr = (kind == 2'd2);
        int idx;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_vaddr = va;
        #(CLK_NS/4);
        idx = m_find(vpn);
        was_hit = done;
        if (idx >= 0) begin
            chk(done, 1, "R1 hit done");
            chk(done_paddr, {pt_ppn(vpn), va[11:0]}, "R1 hit paddr");
            chk(done_prot, wr && m_ro[idx], "R7/R11 hit prot");
            if (wr && !m_ro[idx]) m_dirty[idx] = 1'b1;
            chk(done_dirty, m_dirty[idx], "R8 hit dirty");
            chk(done_pfault, 0, "R1 hit no fault");
            m_stamp[idx] = ++now_stamp;
            @(negedge clk);
            req_valid = 1'b0;
            chk(pt_req, 0, "R1 no pt request on hit");
        end else begin
            chk(done, 0, "R2 miss no done");
            @(negedge clk);
            req_valid = stray;
            req_vaddr = va ^ 64'h0000_0ABC_0000_5000;
            req_kind = 2'd2;
            #(CLK_NS/4);
            chk(busy, 1, "R10 busy after miss");
            chk(pt_req, 1, "R2 pt request");
            chk(pt_req_vpn, vpn, "R2 pt vpn");
            chk(done, 0, "R10 stray ignored");
            @(negedge clk);
            chk(pt_req, 0, "R2 pt pulse");
            for (int d = 0; d < delay; d++) @(negedge clk);
            req_valid = 1'b0;
            pt_rsp_valid = 1'b1; pt_rsp_resident = pt_res(vpn);
            pt_rsp_ro = pt_rdonly(vpn); pt_rsp_ppn = pt_ppn(vpn);
            #(CLK_NS/4);
            chk(done, 1, "R2 done on response");
            if (pt_res(vpn)) begin
                chk(done_pfault, 0, "R2 resident no fault");
                chk(done_paddr, {pt_ppn(vpn), va[11:0]}, "R2 fill paddr");
                chk(done_prot, wr && pt_rdonly(vpn), "R7/R11 fill prot");
                chk(done_dirty, wr && !pt_rdonly(vpn), "R8 fill dirty");
                idx = m_victim();
                m_valid[idx] = 1'b1; m_vpn[idx] = vpn; m_ro[idx] = pt_rdonly(vpn);
                m_dirty[idx] = wr && !pt_rdonly(vpn);
                m_stamp[idx] = ++now_stamp;
            end else begin
                chk(done_pfault, 1, "R3 page fault");
                chk(done_prot, 0, "R3 fault no prot");
                chk(done_dirty, 0, "R3 fault no dirty");
            end
            @(negedge clk);
            pt_rsp_valid = 1'b0;
            chk(busy, 0, "R10 busy released");
        end
    endtask

    task automatic do_flush(input logic [63:0] va);
        @(negedge clk);
        flush = 1'b1; req_valid = 1'b1; req_kind = 2'd1; req_vaddr = va;
        #(CLK_NS/4);
        chk(done, 0, "R9 request ignored in flush");
        @(negedge clk);
        chk(pt_req, 0, "R9 no pt request in flush");
        flush = 1'b0; req_valid = 1'b0;
        for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
    endtask

    function automatic logic [63:0] mkva(input logic [51:0] v, input logic [11:0] o);
        return {v, o};
    endfunction

    initial begin
        bit h;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_NS/4);
        chk(busy, 0, "R10 reset busy");
        chk(done, 0, "R1 reset done");
        chk(pt_req, 0, "R2 reset pt request");

        // R6: four installs then four hits
        access(2'd1, mkva(52'h20, 12'h004), 0, 0, h); chk(h, 0, "R2 first miss");
        access(2'd2, mkva(52'h21, 12'h010), 1, 1, h);
        access(2'd0, mkva(52'h22, 12'hFF8), 0, 2, h);
        access(2'd1, mkva(52'h23, 12'h123), 0, 0, h);
        access(2'd1, mkva(52'h20, 12'h555), 0, 0, h); chk(h, 1, "R6 slot 0x20 kept");
        access(2'd1, mkva(52'h21, 12'h556), 0, 0, h); chk(h, 1, "R6 slot 0x21 kept");
        chk(done_dirty, 1, "R8 dirty persists on read");
        access(2'd1, mkva(52'h22, 12'h557), 0, 0, h); chk(h, 1, "R6 slot 0x22 kept");
        access(2'd1, mkva(52'h23, 12'h558), 0, 0, h); chk(h, 1, "R4 refilled hits");
        // write to read-only page 0x22
        access(2'd2, mkva(52'h22, 12'h0A0), 0, 0, h);
        chk(done_prot, 1, "R7 write to read-only");
        access(2'd0, mkva(52'h22, 12'h0A4), 0, 0, h);
        chk(done_dirty, 0, "R7 page stays clean");
        chk(done_prot, 0, "R11 fetch read-only no prot");
        // R5: LRU is 0x20 now (order 21,23,22 touched after); touch 0x20, evict 0x21
        access(2'd1, mkva(52'h20, 12'h000), 0, 0, h);
        access(2'd1, mkva(52'h24, 12'h000), 0, 1, h); chk(h, 0, "R5 new page misses");
        access(2'd1, mkva(52'h20, 12'h000), 0, 0, h); chk(h, 1, "R5 recent page kept");
        access(2'd1, mkva(52'h21, 12'h000), 0, 0, h); chk(h, 0, "R5 LRU page evicted");
        // R3: non-resident page
        access(2'd1, mkva(52'h26, 12'h008), 0, 0, h);
        access(2'd1, mkva(52'h26, 12'h008), 0, 0, h); chk(h, 0, "R3 no install on fault");
        // R9: flush
        do_flush(mkva(52'h20, 12'h000));
        access(2'd1, mkva(52'h20, 12'h000), 0, 0, h); chk(h, 0, "R9 miss after flush");

        for (int n = 0; n < 400; n++) begin
            logic [51:0] v;
            int sel = $urandom % 9;
            v = (sel == 8) ? 52'h8_0000_0000_0021 : 52'h20 + 52'(sel);
            if ($urandom % 50 == 0) do_flush(mkva(v, 12'h0));
            access(2'($urandom % 4), mkva(v, 12'($urandom)), ($urandom % 3) == 0,
                   $urandom % 3, h);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule